// File: doc/BRIEF.md
# Store-and-Forward Packet FIFO

This block is a single-clock AXI4-Stream buffer that carries data, a per-byte keep mask and an end-of-packet flag. It holds back every packet until the packet's final beat (tlast high) has been written. Only then does it offer that packet on the output. Once a packet starts to leave, the output valid stays high on every cycle until the final beat is taken. A downstream transmitter that cannot accept a bubble inside a frame can therefore be fed straight from it.

The buffer counts how many whole packets it holds and shows that count on a port. The output valid depends on that count, and on whether a packet is partly read out. It does not depend on the buffer being non-empty. The read side is first-word-fall-through: the head word is on the output bus whenever valid is high. Every packet must fit in the storage. A packet longer than DEPTH beats is outside the block's contract.

Top module: `sf_pkt_fifo`

## Requirements
- R1: After reset, out_tvalid is 0, in_tready is 1 and pkt_count is 0.
- R2: Beats of a packet whose tlast beat has not yet been written are never presented. While no whole packet is stored and none is partly read out, out_tvalid is 0.
- R3: In the cycle after a tlast beat is accepted (in_tvalid and in_tready high with in_tlast), out_tvalid is 1.
- R4: Once out_tvalid is 1 for a packet, it stays 1 on every cycle until that packet's tlast beat is accepted (out_tvalid and out_tready high with out_tlast). This holds even if the writer stalls meanwhile.
- R5: Words leave in the order they were written. out_tdata, out_tkeep and out_tlast show the oldest stored word whenever out_tvalid is 1. out_tkeep bit i qualifies byte i, where byte i is bits 8i+7 to 8i of the data.
- R6: in_tready is 0 exactly when DEPTH words are stored. A beat offered while in_tready is 0 is not stored and never appears at the output.
- R7: pkt_count rises by one for each accepted tlast write and falls by one for each accepted tlast read. It is unchanged when both happen in the same cycle.
- R8: While out_tvalid is 1 and out_tready is 0, out_tdata, out_tkeep and out_tlast hold their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_tdata | input | DATA_W | Write data |
| in_tkeep | input | DATA_W/8 | Write byte qualifiers |
| in_tlast | input | 1 | Final beat of the packet being written |
| in_tvalid | input | 1 | Write beat offered |
| in_tready | output | 1 | Space for a beat |
| out_tdata | output | DATA_W | Head word data |
| out_tkeep | output | DATA_W/8 | Head word byte qualifiers |
| out_tlast | output | 1 | Head word ends a packet |
| out_tvalid | output | 1 | Head word may be taken |
| out_tready | input | 1 | Consumer takes the head word |
| pkt_count | output | $clog2(DEPTH)+1 | Whole packets currently stored |

## Verification
A tlast beat can be written in the same cycle as a tlast beat is read, and the packet count must stay flat when that happens. The bench runs many packets of mixed lengths through a small buffer. The writer pauses on a modular cadence, and the reader's ready pattern is skewed differently against that cadence. This makes the two ends cross often. Every cycle, pkt_count is compared with a count kept from the accepted beats, and the bench records how many times both packet ends fell in one cycle so that the case is known to have occurred. The same runs also make a writer stall line up with a packet that is partly read out. Each cycle the bench checks out_tvalid against the rule that it follows whole packets, or a packet already being read, and never mere occupancy.

// File: rtl/sf_pkt_fifo.sv
module sf_pkt_fifo #(
  parameter int DATA_W = 128,
  parameter int DEPTH  = 1024,
  localparam int KEEP_W = DATA_W / 8,
  localparam int AW     = $clog2(DEPTH),
  localparam int WORD_W = DATA_W + KEEP_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] in_tdata,
  input  logic [KEEP_W-1:0] in_tkeep,
  input  logic              in_tlast,
  input  logic              in_tvalid,
  output logic              in_tready,
  output logic [DATA_W-1:0] out_tdata,
  output logic [KEEP_W-1:0] out_tkeep,
  output logic              out_tlast,
  output logic              out_tvalid,
  input  logic              out_tready,
  output logic [AW:0]       pkt_count
);

  localparam logic [AW:0] PTR_ONE = 1;

  logic [WORD_W-1:0] mem [DEPTH];
  logic [AW:0]       wr_ptr, rd_ptr, pkt_cnt;
  logic              in_frame;
  logic              full, wr_fire, rd_fire, wr_end, rd_end;
  logic [WORD_W-1:0] head;

  assign full    = (wr_ptr[AW] != rd_ptr[AW]) && (wr_ptr[AW-1:0] == rd_ptr[AW-1:0]);
  assign wr_fire = in_tvalid && !full;
  assign rd_fire = out_tvalid && out_tready;
  assign wr_end  = wr_fire && in_tlast;
  assign rd_end  = rd_fire && head[0];
  assign head    = mem[rd_ptr[AW-1:0]];

  assign in_tready  = !full;
  assign out_tvalid = (pkt_cnt != '0) || in_frame;
  assign out_tdata  = head[WORD_W-1 -: DATA_W];
  assign out_tkeep  = head[KEEP_W:1];
  assign out_tlast  = head[0];
  assign pkt_count  = pkt_cnt;

  always_ff @(posedge clk)
    if (wr_fire) mem[wr_ptr[AW-1:0]] <= {in_tdata, in_tkeep, in_tlast};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      pkt_cnt  <= '0;
      in_frame <= 1'b0;
    end else begin
      if (wr_fire) wr_ptr <= wr_ptr + PTR_ONE;
      if (rd_fire) begin
        rd_ptr   <= rd_ptr + PTR_ONE;
        in_frame <= !head[0];
      end
      case ({wr_end, rd_end})
        2'b10:   pkt_cnt <= pkt_cnt + PTR_ONE;
        2'b01:   pkt_cnt <= pkt_cnt - PTR_ONE;
        default: pkt_cnt <= pkt_cnt;
      endcase
    end
  end

  initial begin
    if (DEPTH < 2 || (1 << AW) != DEPTH) $error("DEPTH must be a power of two, at least 2");
    if (DATA_W % 8 != 0) $error("DATA_W must be a whole number of bytes");
  end

endmodule

// File: rtl/sf_pkt_fifo_chk.sv
module sf_pkt_fifo_chk #(
  parameter int DATA_W = 128,
  parameter int DEPTH  = 1024,
  localparam int KEEP_W = DATA_W / 8,
  localparam int AW     = $clog2(DEPTH)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_tlast,
  input logic              in_tvalid,
  input logic              in_tready,
  input logic [DATA_W-1:0] out_tdata,
  input logic [KEEP_W-1:0] out_tkeep,
  input logic              out_tlast,
  input logic              out_tvalid,
  input logic              out_tready,
  input logic [AW:0]       pkt_count
);

  localparam logic [AW:0] ONE = 1;
  localparam logic [AW:0] FULL_OCC = DEPTH;

  logic [AW:0] occ, ends;
  logic        mid;
  logic        wf, rf;

  assign wf = in_tvalid && in_tready;
  assign rf = out_tvalid && out_tready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      occ  <= '0;
      ends <= '0;
      mid  <= 1'b0;
    end else begin
      occ <= occ + (wf ? ONE : '0) - (rf ? ONE : '0);
      ends <= ends + ((wf && in_tlast) ? ONE : '0) - ((rf && out_tlast) ? ONE : '0);
      if (rf) mid <= !out_tlast;
    end
  end

  AST_NO_EARLY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (ends == '0 && !mid) |-> !out_tvalid); // R2
  AST_VALID_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
    (wf && in_tlast) |=> out_tvalid); // R3
  AST_NO_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (out_tvalid && !(out_tready && out_tlast)) |=> out_tvalid); // R4
  AST_FULL_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == FULL_OCC) |-> !in_tready); // R6
  AST_ROOM_ACCEPTS: assert property (@(posedge clk) disable iff (!rst_n)
    (occ != FULL_OCC) |-> in_tready); // R6
  AST_COUNT_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_count == ends); // R7
  AST_HOLD_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_tvalid && !out_tready) |=> $stable({out_tdata, out_tkeep, out_tlast})); // R8

endmodule

bind sf_pkt_fifo sf_pkt_fifo_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_tlast(in_tlast), .in_tvalid(in_tvalid),
  .in_tready(in_tready), .out_tdata(out_tdata), .out_tkeep(out_tkeep),
  .out_tlast(out_tlast), .out_tvalid(out_tvalid), .out_tready(out_tready),
  .pkt_count(pkt_count)
);

// File: tb/sf_pkt_fifo_test.sv
module sf_pkt_fifo_test;
  localparam int DW = 16;
  localparam int KW = DW / 8;
  localparam int DP = 8;
  localparam int AW = $clog2(DP);

  typedef struct packed { logic [DW-1:0] d; logic [KW-1:0] k; logic l; } beat_t;

  logic clk = 0, rst_n = 0;
  logic [DW-1:0] in_tdata = '0;
  logic [KW-1:0] in_tkeep = '0;
  logic in_tlast = 0, in_tvalid = 0, in_tready;
  logic [DW-1:0] out_tdata;
  logic [KW-1:0] out_tkeep;
  logic out_tlast, out_tvalid, out_tready = 0;
  logic [AW:0] pkt_count;

  sf_pkt_fifo #(.DATA_W(DW), .DEPTH(DP)) uut (.*);

  always #4 clk = ~clk;

  int checks = 0, errors = 0, coinc = 0, ignored = 0;
  beat_t wq[$], eq[$];
  int mcnt = 0;
  bit started = 0, hold = 0;
  beat_t prev;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic add_pkt(input int id, input int len);
    for (int b = 0; b < len; b++) begin
      beat_t x;
      x.d = {id[7:0], b[7:0]};
      x.k = (b == len - 1 && len % 2 == 1) ? 2'b01 : 2'b11;
      x.l = (b == len - 1);
      wq.push_back(x);
    end
  endtask

  task automatic step(input bit wen, input bit rdy);
    bit wf, rf, expv;
    beat_t o;
    @(negedge clk);
    in_tvalid = wen && wq.size() > 0;
    if (in_tvalid) {in_tdata, in_tkeep, in_tlast} = wq[0];
    out_tready = rdy;
    #1;
    o = '{out_tdata, out_tkeep, out_tlast};
    expv = (mcnt > 0) || started;
    chk(out_tvalid == expv, "R2/R3/R4 out_tvalid", out_tvalid, expv);
    chk(in_tready == (eq.size() < DP), "R6 in_tready", in_tready, eq.size() < DP);
    chk(pkt_count == mcnt, "R7 pkt_count", pkt_count, mcnt);
    if (out_tvalid && eq.size() > 0) chk(o == eq[0], "R5 head word", o, eq[0]);
    if (hold) chk(o == prev, "R8 held word", o, prev);
    if (in_tvalid && !in_tready) ignored++;
    wf = in_tvalid && in_tready;
    rf = out_tvalid && out_tready;
    if (wf && in_tlast && rf && out_tlast) coinc++;
    hold = out_tvalid && !out_tready;
    prev = o;
    @(posedge clk);
    if (wf) begin
      if (wq[0].l) mcnt++;
      eq.push_back(wq.pop_front());
    end
    if (rf && eq.size() > 0) begin
      beat_t h = eq.pop_front();
      if (h.l) mcnt--;
      started = !h.l;
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int id = 0;
    repeat (3) @(posedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    chk(out_tvalid == 0, "R1 out_tvalid", out_tvalid, 0);
    chk(in_tready == 1, "R1 in_tready", in_tready, 1);
    chk(pkt_count == 0, "R1 pkt_count", pkt_count, 0);

    // Sweep all lengths: fill with consumer stalled, then drain with a gappy ready.
    for (int len = 1; len <= DP; len++) begin
      add_pkt(id++, len);
      for (int n = 0; n < 40 && wq.size() > 0; n++) step(1, 0);
      if (len == DP) begin
        add_pkt(99, 1);
        repeat (3) step(1, 0);
        wq.delete();
      end
      for (int n = 0; n < 60 && eq.size() > 0; n++) step(0, (n % 3) != 1);
    end
    chk(ignored > 0, "R6 write while full was offered", ignored, 1);

    // Mixed streams with both ends active; writer stalls and reader gaps interleave.
    for (int p = 0; p < 12; p++) begin
      for (int k = 0; k < 6; k++) add_pkt(id++, ((k * 3 + p) % 5) + 1);
      for (int c = 0; c < 600 && (wq.size() > 0 || eq.size() > 0); c++)
        step(((c + p) % 4) != 3, (p == 0) || ((c * (p + 1)) % 5 != 0));
    end
    chk(coinc > 0, "R7 tlast write and read in one cycle", coinc, 1);
    chk(eq.size() == 0 && wq.size() == 0, "R5 all beats delivered", eq.size() + wq.size(), 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule